// File: doc/BRIEF.md
# Byte Manipulation Shift Unit

This block is a 64-bit execution unit for shifts and byte-granular field operations. Each cycle it may accept operand A, operand B (a register value or a literal, the unit does not care which) and a 7-bit function code, qualified by a valid strobe. One cycle later it presents the 64-bit result and a flag that marks an unrecognised function code. Both outputs are held in a register that changes only when a valid operation is accepted.

Besides logical and arithmetic shifts, the unit offers the byte-lane toolkit used to assemble unaligned loads and stores from aligned quadwords. It can clear a field in place, pull a field out of a quadword, or place a field into position. Each of these comes in a low and a high form, and the field may be 1, 2, 4 or 8 bytes wide. The byte offset is taken from B, and the high forms treat an offset of zero as a special case. A byte zap and its inverse clear bytes of A under an 8-bit select taken from B. Address generation and memory access stay outside the block.

Top module: `bytelane_shift_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `res` becomes zero and `illegal` becomes 0 after that edge.
- R2: At a rising edge with `in_valid` high, `res` and `illegal` take the value for that cycle's inputs, visible after the edge. At an edge with `in_valid` low, both keep their previous values whatever the other inputs do.
- R3: Code 0x39 shifts A left logically, 0x34 shifts A right logically and 0x3c shifts A right arithmetically (sign bit copied in). In all three the shift amount is B[5:0].
- R4: In all mask, extract and insert codes, off = B[2:0] and sz is the field size in bytes: 1, 2, 4 or 8 for code bits [5:4] = 0, 1, 2, 3. Mask-low codes 0x02, 0x12, 0x22, 0x32 return A with byte j cleared for every j where off <= j < off+sz; bytes past byte 7 are dropped.
- R5: Mask-high codes 0x52, 0x62, 0x72 (sz 2, 4, 8) return A unchanged when off = 0. Otherwise they return A with byte j cleared for every j < off+sz-8.
- R6: Extract-low codes 0x06, 0x16, 0x26, 0x36 give result byte j = A byte j+off when j < sz and j+off <= 7, and zero otherwise.
- R7: Extract-high codes 0x5a, 0x6a, 0x7a (sz 2, 4, 8) use k = (8-off) mod 8. They give result byte j = A byte j-k when k <= j < sz, and zero otherwise.
- R8: Insert-low codes 0x0b, 0x1b, 0x2b, 0x3b give result byte j = A byte j-off when j >= off and j-off < sz, and zero otherwise.
- R9: Insert-high codes 0x57, 0x67, 0x77 (sz 2, 4, 8) give zero when off = 0. Otherwise they give result byte j = A byte j+8-off when j+8-off < sz, and zero otherwise.
- R10: Code 0x30 clears byte j of A for each j with B[j] = 1. Code 0x31 clears byte j of A for each j with B[j] = 0.
- R11: Any code not listed in R3 to R10 sets `illegal` to 1 and `res` to zero. Every listed code sets `illegal` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept the operands and code this cycle |
| func | input | 7 | Function code |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Operand B, register value or literal |
| res | output | 64 | Registered result |
| illegal | output | 1 | Registered unrecognised-code flag |

## Verification
The bench builds the unit with its default 64-bit, 8-byte configuration, where the function-code space is only 128 entries. That allows every code, legal or not, to be driven against several operand patterns and against all 64 values of B[5:0]. This covers every shift amount and every byte offset, including offset zero for each high form. The zap select bits vary across the same sweep, and a separate pass with the strobe low confirms that the register holds its value.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_SHL,
    OP_SHR,
    OP_SAR,
    OP_CLR_LO,
    OP_CLR_HI,
    OP_GET_LO,
    OP_GET_HI,
    OP_PUT_LO,
    OP_PUT_HI,
    OP_ZAP,
    OP_KEEP
  } bsu_op_e;

  typedef struct packed {
    bsu_op_e    op;
    logic [1:0] size_log2;
    logic       legal;
  } bsu_dec_t;

endpackage

// File: rtl/bsu_decode.sv
module bsu_decode
  import bsu_pkg::*;
#(
  parameter int FUNC_W = 7
) (
  input  logic [FUNC_W-1:0] func,
  output bsu_dec_t          dec
);

  always_comb begin
    dec.op        = OP_NONE;
    dec.size_log2 = func[5:4];
    case (func)
      7'h39: dec.op = OP_SHL;
      7'h34: dec.op = OP_SHR;
      7'h3c: dec.op = OP_SAR;
      7'h02, 7'h12, 7'h22, 7'h32: dec.op = OP_CLR_LO;
      7'h52, 7'h62, 7'h72:        dec.op = OP_CLR_HI;
      7'h06, 7'h16, 7'h26, 7'h36: dec.op = OP_GET_LO;
      7'h5a, 7'h6a, 7'h7a:        dec.op = OP_GET_HI;
      7'h0b, 7'h1b, 7'h2b, 7'h3b: dec.op = OP_PUT_LO;
      7'h57, 7'h67, 7'h77:        dec.op = OP_PUT_HI;
      7'h30: dec.op = OP_ZAP;
      7'h31: dec.op = OP_KEEP;
      default: dec.op = OP_NONE;
    endcase
    dec.legal = (dec.op != OP_NONE);
  end

endmodule

// File: rtl/bsu_shifter.sv
module bsu_shifter
  import bsu_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  bsu_op_e             op,
  input  logic [DATA_W-1:0]   a,
  input  logic [SHAMT_W-1:0]  amt,
  output logic [DATA_W-1:0]   y
);

  always_comb begin
    case (op)
      OP_SHL:  y = a << amt;
      OP_SHR:  y = a >> amt;
      OP_SAR:  y = DATA_W'($signed(a) >>> amt);
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/bsu_field.sv
module bsu_field
  import bsu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8,
  parameter int NBYTES = DATA_W / BYTE_W,
  parameter int OFF_W  = $clog2(NBYTES)
) (
  input  bsu_op_e           op,
  input  logic [1:0]        size_log2,
  input  logic [DATA_W-1:0] a,
  input  logic [OFF_W-1:0]  off,
  output logic [DATA_W-1:0] y
);

  localparam int SHAMT_W = $clog2(DATA_W);

  logic [DATA_W-1:0]  fmask;
  logic [SHAMT_W:0]   fbits;
  logic [SHAMT_W-1:0] bshift;
  logic [SHAMT_W:0]   rshift;
  logic [DATA_W-1:0]  afield;
  logic               off_zero;

  // field of 1, 2, 4 or 8 bytes; a full-width shift leaves zero, so ~0
  assign fbits    = (SHAMT_W+1)'(BYTE_W) << size_log2;
  assign fmask    = ~({DATA_W{1'b1}} << fbits);
  assign bshift   = SHAMT_W'(off) * SHAMT_W'(BYTE_W);
  assign rshift   = (SHAMT_W+1)'(DATA_W) - {1'b0, bshift};
  assign afield   = a & fmask;
  assign off_zero = (off == '0);

  always_comb begin
    case (op)
      OP_CLR_LO: y = a & ~(fmask << bshift);
      OP_CLR_HI: y = off_zero ? a : (a & ~(fmask >> rshift));
      OP_GET_LO: y = (a >> bshift) & fmask;
      OP_GET_HI: y = (a << rshift[SHAMT_W-1:0]) & fmask;
      OP_PUT_LO: y = afield << bshift;
      OP_PUT_HI: y = off_zero ? '0 : (afield >> rshift);
      default:   y = '0;
    endcase
  end

endmodule

// File: rtl/bsu_zap.sv
module bsu_zap
  import bsu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8,
  parameter int NBYTES = DATA_W / BYTE_W
) (
  input  bsu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [NBYTES-1:0] sel,
  output logic [DATA_W-1:0] y
);

  logic [NBYTES-1:0] keep;

  assign keep = (op == OP_KEEP) ? sel : ~sel;

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign y[g*BYTE_W +: BYTE_W] =
      ((op == OP_ZAP) || (op == OP_KEEP)) && keep[g] ? a[g*BYTE_W +: BYTE_W]
                                                     : '0;
  end

endmodule

// File: rtl/bytelane_shift_unit.sv
module bytelane_shift_unit
  import bsu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8,
  parameter int FUNC_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [FUNC_W-1:0] func,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic [DATA_W-1:0] res,
  output logic              illegal
);

  localparam int NBYTES  = DATA_W / BYTE_W;
  localparam int OFF_W   = $clog2(NBYTES);
  localparam int SHAMT_W = $clog2(DATA_W);

  bsu_dec_t          dec;
  logic [DATA_W-1:0] y_shift;
  logic [DATA_W-1:0] y_field;
  logic [DATA_W-1:0] y_zap;
  logic [DATA_W-1:0] y_next;
  logic              unused_b;

  assign unused_b = ^op_b[DATA_W-1:SHAMT_W];

  bsu_decode #(.FUNC_W(FUNC_W)) i_decode (
    .func (func),
    .dec  (dec)
  );

  bsu_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) i_shifter (
    .op  (dec.op),
    .a   (op_a),
    .amt (op_b[SHAMT_W-1:0]),
    .y   (y_shift)
  );

  bsu_field #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES), .OFF_W(OFF_W)) i_field (
    .op        (dec.op),
    .size_log2 (dec.size_log2),
    .a         (op_a),
    .off       (op_b[OFF_W-1:0]),
    .y         (y_field)
  );

  bsu_zap #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) i_zap (
    .op  (dec.op),
    .a   (op_a),
    .sel (op_b[NBYTES-1:0]),
    .y   (y_zap)
  );

  // each unit drives zero for codes it does not own
  assign y_next = y_shift | y_field | y_zap;

  always_ff @(posedge clk) begin
    if (rst) begin
      res     <= '0;
      illegal <= 1'b0;
    end else if (in_valid) begin
      res     <= y_next;
      illegal <= ~dec.legal;
    end
  end

endmodule

module bsu_checker #(
  parameter int DATA_W = 64,
  parameter int FUNC_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [FUNC_W-1:0] func,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [DATA_W-1:0] res,
  input logic              illegal
);

  logic unused_chk;
  assign unused_chk = ^op_b[DATA_W-1:3];

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (res == '0 && !illegal)); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(res) && $stable(illegal))); // R2

  AST_SAR_SIGN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && func == 7'h3c && op_a[DATA_W-1]) |=> res[DATA_W-1]); // R3

  AST_CLRHI_PASS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && func == 7'h72 && op_b[2:0] == 3'd0) |=> (res == $past(op_a))); // R5

  AST_PUTHI_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && func[3:0] == 4'h7 && func[6] && op_b[2:0] == 3'd0) |=> (res == '0)); // R9

  AST_ZAP_SUBSET: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (func == 7'h30 || func == 7'h31)) |=> ((res & ~$past(op_a)) == '0)); // R10

  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (res == '0)); // R11

endmodule

bind bytelane_shift_unit bsu_checker #(.DATA_W(DATA_W), .FUNC_W(FUNC_W)) i_bsu_checker (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .func     (func),
  .op_a     (op_a),
  .op_b     (op_b),
  .res      (res),
  .illegal  (illegal)
);

// File: tb/test_bytelane_shift_unit.sv
`timescale 1ns/1ps
module test_bytelane_shift_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [6:0]  func = '0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic [63:0] res;
  logic        illegal;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  bytelane_shift_unit i_bytelane_shift_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .func(func),
    .op_a(op_a), .op_b(op_b), .res(res), .illegal(illegal)
  );

  function automatic string tag_of(input logic [6:0] f);
    case (f)
      7'h39, 7'h34, 7'h3c:        return "R3";
      7'h02, 7'h12, 7'h22, 7'h32: return "R4";
      7'h52, 7'h62, 7'h72:        return "R5";
      7'h06, 7'h16, 7'h26, 7'h36: return "R6";
      7'h5a, 7'h6a, 7'h7a:        return "R7";
      7'h0b, 7'h1b, 7'h2b, 7'h3b: return "R8";
      7'h57, 7'h67, 7'h77:        return "R9";
      7'h30, 7'h31:               return "R10";
      default:                    return "R11";
    endcase
  endfunction

  // returns {illegal, result}
  function automatic logic [64:0] model(input logic [6:0] f, input logic [63:0] a,
                                        input logic [63:0] b);
    logic [63:0] y;
    int sz;
    int off;
    int k;
    y   = '0;
    sz  = 1 << f[5:4];
    off = int'(b[2:0]);
    k   = (8 - off) % 8;
    case (f)
      7'h39: return {1'b0, a << b[5:0]};
      7'h34: return {1'b0, a >> b[5:0]};
      7'h3c: return {1'b0, 64'($signed(a) >>> b[5:0])};
      7'h02, 7'h12, 7'h22, 7'h32: begin
        for (int j = 0; j < 8; j++)
          y[j*8 +: 8] = (j >= off && j < off + sz) ? 8'h00 : a[j*8 +: 8];
      end
      7'h52, 7'h62, 7'h72: begin
        for (int j = 0; j < 8; j++)
          y[j*8 +: 8] = (off != 0 && j < off + sz - 8) ? 8'h00 : a[j*8 +: 8];
      end
      7'h06, 7'h16, 7'h26, 7'h36: begin
        for (int j = 0; j < 8; j++)
          if (j < sz && j + off <= 7) y[j*8 +: 8] = a[(j+off)*8 +: 8];
      end
      7'h5a, 7'h6a, 7'h7a: begin
        for (int j = 0; j < 8; j++)
          if (j >= k && j < sz) y[j*8 +: 8] = a[(j-k)*8 +: 8];
      end
      7'h0b, 7'h1b, 7'h2b, 7'h3b: begin
        for (int j = 0; j < 8; j++)
          if (j >= off && j - off < sz) y[j*8 +: 8] = a[(j-off)*8 +: 8];
      end
      7'h57, 7'h67, 7'h77: begin
        if (off != 0)
          for (int j = 0; j < 8; j++)
            if (j + 8 - off < sz) y[j*8 +: 8] = a[(j+8-off)*8 +: 8];
      end
      7'h30: begin
        for (int j = 0; j < 8; j++) y[j*8 +: 8] = b[j] ? 8'h00 : a[j*8 +: 8];
      end
      7'h31: begin
        for (int j = 0; j < 8; j++) y[j*8 +: 8] = b[j] ? a[j*8 +: 8] : 8'h00;
      end
      default: return {1'b1, 64'h0};
    endcase
    return {1'b0, y};
  endfunction

  task automatic check(input string tag, input logic [64:0] act, input logic [64:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s func=%h a=%h b=%h: got ill=%b res=%h, want ill=%b res=%h",
               tag, func, op_a, op_b, act[64], act[63:0], exp[64], exp[63:0]);
    end
  endtask

  task automatic run_op(input logic [6:0] f, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    func = f; op_a = a; op_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag_of(f), {illegal, res}, model(f, a, b));
  endtask

  initial begin
    logic [63:0] pats [4];
    logic [64:0] held;
    pats[0] = 64'h0123_4567_89ab_cdef;
    pats[1] = 64'hfedc_ba98_7654_3210;
    pats[2] = 64'h8000_0000_0000_0001;
    pats[3] = 64'hffff_ffff_ffff_ffff;

    // R1: reset state, even with a strobe present
    in_valid = 1'b1; func = 7'h00; op_a = pats[3];
    repeat (3) @(negedge clk);
    check("R1 reset", {illegal, res}, 65'h0);
    rst = 1'b0; in_valid = 1'b0;

    // R3..R11: every code against every B[5:0]
    for (int f = 0; f < 128; f++)
      for (int p = 0; p < 4; p++)
        for (int bi = 0; bi < 64; bi++)
          run_op(7'(f), pats[p],
                 ((pats[p] ^ 64'h9e37_79b9_7f4a_7c15) & ~64'h3f) | 64'(bi));

    // R2: strobe low holds result and flag
    run_op(7'h2b, pats[0], 64'h5);
    held = {illegal, res};
    @(negedge clk);
    func = 7'h00; op_a = pats[1]; op_b = 64'h3;
    repeat (2) @(negedge clk);
    check("R2 hold legal", {illegal, res}, held);
    run_op(7'h7f, pats[0], 64'h0);
    held = {illegal, res};
    @(negedge clk);
    func = 7'h39; op_a = pats[3]; op_b = 64'h4;
    repeat (2) @(negedge clk);
    check("R2 hold illegal", {illegal, res}, held);

    // R1: reset in mid-run clears a nonzero result
    run_op(7'h36, pats[3], 64'h0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 mid-run reset", {illegal, res}, 65'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got hung, want completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule